// File: doc/BRIEF.md
# Three-Wire Serial Display Memory Port

This block connects a host to a 32-entry by 4-bit display memory over a three-strobe serial link: an active-low select, a write strobe, a read strobe and a single bidirectional data line. The host opens a frame by pulling select low and clocking in a 3-bit frame code on write-strobe rising edges. The code picks one of three data access modes (write, read, or read-modify-write on a write frame) or a command frame. A data frame then carries a start address and a stream of nibbles. The address steps forward after every nibble, so one frame can fill or dump a run of entries. A command frame carries any number of 9-bit command words. Each complete word is presented on a one-cycle strobe.

All port lines are brought into the fast core clock through synchronizer chains. Edges are detected on the synchronized levels, and the memory and the frame logic run entirely in the core clock. During reads the block drives the data line and raises an output enable that tells the pad to leave its high-impedance state. A second read port, addressed independently, lets the display scan logic read the memory at any time.

Top module: `sdi_port`

## Requirements
- R1: While select is high, strobes have no effect, the frame logic returns to waiting for a frame code, and the data output enable is low. Raising select in the middle of a frame drops that frame.
- R2: The frame code is the first three bits, first bit most significant. 101 selects a write frame, 110 a read frame and 100 a command frame. Any other code makes the rest of the frame, reads included, have no effect.
- R3: Bits are taken from the data line on write-strobe rising edges. In data frames the address is the next 6 bits, most significant first. Its top bit is ignored, so the entry is the low 5 bits.
- R4: In a write frame, nibble bits arrive least significant first. An entry is written only when the fourth bit of its nibble arrives. A partial nibble at the end of a frame is discarded.
- R5: The address advances by one after each complete nibble and wraps from 31 to 0.
- R6: In a read frame, each read-strobe falling edge drives the next bit of the addressed entry onto the data line, least significant first. The bit stays valid through the following rising edge. The address advances after the fourth bit.
- R7: The data output enable rises at the first read-strobe falling edge of a data phase and stays high until select goes high. It never rises in the frame code, address or command phases.
- R8: In a write frame, read-strobe falling edges shift out the current entry's old contents least significant first without moving the address. This allows read-modify-write of each nibble before it is rewritten.
- R9: A command frame delivers each 9-bit word, most significant first, as a one-cycle pulse on cmd_valid_o with the word on cmd_o. Words repeat until select rises, and a partial word is discarded.
- R10: Write-strobe bits during the data phase of a read frame leave the memory and the read address untouched.
- R11: Reset clears every memory entry to zero. scan_data_o shows the entry at scan_addr_i without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| wr_i | input | 1 | Write strobe, idle high, sampled on rising edge |
| rd_i | input | 1 | Read strobe, idle high, data driven after falling edge |
| data_i | input | 1 | Data line as seen at the pad input |
| data_o | output | 1 | Data line value driven during reads |
| data_oe_o | output | 1 | Enable for driving data_o onto the pad |
| cmd_valid_o | output | 1 | One-cycle pulse per complete command word |
| cmd_o | output | 9 | Last complete command word |
| scan_addr_i | input | 5 | Display scan read address |
| scan_data_o | output | 4 | Display scan read data |

## Verification
The bench drives bursts that cross the 31-to-0 boundary in both directions. A design that only carries within the nibble, or stops at the end, would write and read the wrong entries. It sends an address with its top bit set, a nibble cut short by select, and a frame code broken off and restarted. A design that counted the sixth bit, committed partial nibbles or kept stale shift state would corrupt memory. It mixes read strobes into a write frame and write strobes into a read frame, where a wrong design would move the address or overwrite data. It sends back-to-back command words, an unknown frame code and strobes with select high. Lost, extra or misaligned command pulses and stray writes all show up in the scoreboard.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  localparam int ID_W = 3;

  localparam logic [ID_W-1:0] ID_WRITE = 3'b101;
  localparam logic [ID_W-1:0] ID_READ  = 3'b110;
  localparam logic [ID_W-1:0] ID_CMD   = 3'b100;

  typedef enum logic [2:0] {
    PH_ID,
    PH_ADDR,
    PH_DATA,
    PH_CMD,
    PH_SKIP
  } phase_e;

  typedef enum logic {
    AM_WR,
    AM_RD
  } amode_e;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int             WIDTH   = 4,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= in_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdi_ram.sv
module sdi_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))    mem_q[i] <= wdata_i;
    end
  end

  // Out-of-range addresses (non power-of-two depth) read zero
  assign rdata_a_o = (int'(raddr_a_i) < DEPTH) ? mem_q[raddr_a_i] : '0;
  assign rdata_b_o = (int'(raddr_b_i) < DEPTH) ? mem_q[raddr_b_i] : '0;
endmodule

// File: rtl/sdi_fsm.sv
module sdi_fsm
  import sdi_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int NIB_W     = 4,
  parameter int CMD_W     = 9,
  parameter int ADDR_BITS = 6,
  localparam int AW       = $clog2(DEPTH),
  localparam int NB_W     = $clog2(NIB_W),
  localparam int MAXB     = (CMD_W > ADDR_BITS) ? CMD_W : ADDR_BITS,
  localparam int CNT_W    = $clog2(MAXB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_hi_i,
  input  logic             wr_lvl_i,
  input  logic             rd_lvl_i,
  input  logic             din_i,
  // memory side
  output logic             we_o,
  output logic [AW-1:0]    addr_o,
  output logic [NIB_W-1:0] wdata_o,
  input  logic [NIB_W-1:0] rdata_i,
  // host side
  output logic             data_o,
  output logic             data_oe_o,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o
);
  phase_e           ph_q;
  amode_e           mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAXB-1:0]  sh_q, sh_nx;
  logic [AW-1:0]    addr_q, addr_inc;
  logic [NIB_W-1:0] wnib_q;
  logic [NB_W-1:0]  rbit_q, rbit_inc;
  logic             wr_prev_q, rd_prev_q;
  logic             wr_rise, rd_fall;
  logic             dout_q, oe_q, cmd_valid_q;
  logic [CMD_W-1:0] cmd_q;

  assign wr_rise  = wr_lvl_i & ~wr_prev_q;
  assign rd_fall  = ~rd_lvl_i & rd_prev_q;
  assign sh_nx    = {sh_q[MAXB-2:0], din_i};
  assign addr_inc = (addr_q == AW'(DEPTH-1)) ? '0 : addr_q + 1'b1;
  assign rbit_inc = (rbit_q == NB_W'(NIB_W-1)) ? '0 : rbit_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= wr_lvl_i;
      rd_prev_q <= rd_lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_ID;
      mode_q      <= AM_WR;
      cnt_q       <= '0;
      sh_q        <= '0;
      addr_q      <= '0;
      wnib_q      <= '0;
      rbit_q      <= '0;
      dout_q      <= 1'b0;
      oe_q        <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_q       <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      if (cs_hi_i) begin
        ph_q   <= PH_ID;
        cnt_q  <= '0;
        sh_q   <= '0;
        rbit_q <= '0;
        oe_q   <= 1'b0;
        dout_q <= 1'b0;
      end else if (wr_rise) begin
        unique case (ph_q)
          PH_ID: begin
            sh_q <= sh_nx;
            if (cnt_q == CNT_W'(ID_W-1)) begin
              cnt_q <= '0;
              if (sh_nx[ID_W-1:0] == ID_WRITE) begin
                ph_q <= PH_ADDR; mode_q <= AM_WR;
              end else if (sh_nx[ID_W-1:0] == ID_READ) begin
                ph_q <= PH_ADDR; mode_q <= AM_RD;
              end else if (sh_nx[ID_W-1:0] == ID_CMD) begin
                ph_q <= PH_CMD;
              end else begin
                ph_q <= PH_SKIP;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_ADDR: begin
            sh_q <= sh_nx;
            if (cnt_q == CNT_W'(ADDR_BITS-1)) begin
              addr_q <= sh_nx[AW-1:0];   // upper address bits dropped
              ph_q   <= PH_DATA;
              cnt_q  <= '0;
              rbit_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (mode_q == AM_WR) begin
              wnib_q[cnt_q[NB_W-1:0]] <= din_i;
              if (cnt_q == CNT_W'(NIB_W-1)) begin
                cnt_q  <= '0;
                addr_q <= addr_inc;
                rbit_q <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          PH_CMD: begin
            sh_q <= sh_nx;
            if (cnt_q == CNT_W'(CMD_W-1)) begin
              cmd_valid_q <= 1'b1;
              cmd_q       <= sh_nx[CMD_W-1:0];
              cnt_q       <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (rd_fall && ph_q == PH_DATA) begin
        dout_q <= rdata_i[rbit_q];
        oe_q   <= 1'b1;
        rbit_q <= rbit_inc;
        // read frames step the address; write frames only peek (RMW)
        if (mode_q == AM_RD && rbit_q == NB_W'(NIB_W-1)) addr_q <= addr_inc;
      end
    end
  end

  assign we_o        = wr_rise && !cs_hi_i && ph_q == PH_DATA && mode_q == AM_WR
                       && cnt_q == CNT_W'(NIB_W-1);
  assign wdata_o     = {din_i, wnib_q[NIB_W-2:0]};
  assign addr_o      = addr_q;
  assign data_o      = dout_q;
  assign data_oe_o   = oe_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;

  AST_OE_CS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> !data_oe_o); // R1
  AST_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SKIP && !cs_hi_i) |=> ph_q == PH_SKIP); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && addr_q == AW'(DEPTH-1)) |=> addr_q == '0); // R5
  AST_OE_DATA_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ph_q == PH_DATA); // R7
  AST_RMW_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall && !wr_rise && !cs_hi_i && mode_q == AM_WR) |=> $stable(addr_q)); // R8
  AST_CMD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R9
  AST_RD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == AM_RD && ph_q == PH_DATA) |-> !we_o); // R10
endmodule

// File: rtl/sdi_port.sv
module sdi_port #(
  parameter int DEPTH       = 32,
  parameter int NIB_W       = 4,
  parameter int CMD_W       = 9,
  parameter int ADDR_BITS   = 6,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             data_i,
  output logic             data_o,
  output logic             data_oe_o,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o,
  input  logic [AW-1:0]    scan_addr_i,
  output logic [NIB_W-1:0] scan_data_o
);
  logic [3:0]       pin_lvl;
  logic             we;
  logic [AW-1:0]    addr;
  logic [NIB_W-1:0] wdata, rdata;

  sdi_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1111)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({cs_ni, wr_i, rd_i, data_i}),
    .lvl_o (pin_lvl)
  );

  sdi_fsm #(
    .DEPTH    (DEPTH),
    .NIB_W    (NIB_W),
    .CMD_W    (CMD_W),
    .ADDR_BITS(ADDR_BITS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_hi_i    (pin_lvl[3]),
    .wr_lvl_i   (pin_lvl[2]),
    .rd_lvl_i   (pin_lvl[1]),
    .din_i      (pin_lvl[0]),
    .we_o       (we),
    .addr_o     (addr),
    .wdata_o    (wdata),
    .rdata_i    (rdata),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .cmd_valid_o(cmd_valid_o),
    .cmd_o      (cmd_o)
  );

  sdi_ram #(
    .DEPTH(DEPTH),
    .DW   (NIB_W)
  ) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .waddr_i  (addr),
    .wdata_i  (wdata),
    .raddr_a_i(addr),
    .rdata_a_o(rdata),
    .raddr_b_i(scan_addr_i),
    .rdata_b_o(scan_data_o)
  );
endmodule

// File: tb/sim_sdi_port.sv
module sim_sdi_port;
  localparam int HP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr = 1'b1, rd = 1'b1, din = 1'b1;
  logic [4:0] scan_a = '0;
  logic       data_o, data_oe, cmd_valid;
  logic [8:0] cmd;
  logic [3:0] scan_d;

  always #4 clk = ~clk;

  sdi_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_i(wr), .rd_i(rd),
    .data_i(din), .data_o(data_o), .data_oe_o(data_oe),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .scan_addr_i(scan_a), .scan_data_o(scan_d)
  );

  int         errs = 0, checks = 0, cmd_seen = 0;
  logic [3:0] model_m [32];
  bit         exp_rd_q [$];
  logic [8:0] exp_cmd_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_lo(); cs_n = 1'b0; hold(); endtask
  task automatic cs_hi(); cs_n = 1'b1; hold(); endtask

  task automatic wr_bit(input bit b);
    din = b; wr = 1'b0; hold(); wr = 1'b1; hold();
  endtask

  task automatic send_msb(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
  endtask

  task automatic write_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wr_bit(v[i]);
  endtask

  task automatic rd_bit();
    rd = 1'b0; hold(); rd = 1'b1; hold();
  endtask

  task automatic read_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) begin
      exp_rd_q.push_back(v[i]);
      rd_bit();
    end
  endtask

  task automatic scan_chk(input int a, input string req);
    scan_a = 5'(a);
    #1;
    chk(scan_d === model_m[a], req, scan_d, model_m[a]);
  endtask

  // monitor: read bits seen by the host on the rising read strobe
  always @(posedge rd) begin
    if (exp_rd_q.size() > 0) begin
      bit e;
      e = exp_rd_q.pop_front();
      chk(data_o === e, "R6 R8 read bit", data_o, e);
    end
  end

  // monitor: command words
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      cmd_seen++;
      if (exp_cmd_q.size() > 0) begin
        logic [8:0] e;
        e = exp_cmd_q.pop_front();
        chk(cmd === e, "R9 command word", cmd, e);
      end else begin
        chk(1'b0, "R9 unexpected command", cmd, 0);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model_m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hold();

    // reset state: R11, R1
    chk(data_oe === 1'b0, "R1 oe after reset", data_oe, 0);
    chk(cmd_valid === 1'b0, "R9 no cmd after reset", cmd_valid, 0);
    for (int i = 0; i < 32; i++) scan_chk(i, "R11 reset clear");

    // write burst at 3: R3 R4 R5
    cs_lo(); send_msb(3'b101, 3); send_msb(3, 6);
    write_nib(4'hA); write_nib(4'h5); write_nib(4'hC);
    cs_hi();
    model_m[3] = 4'hA; model_m[4] = 4'h5; model_m[5] = 4'hC;
    scan_chk(3, "R4 nibble lsb first"); scan_chk(4, "R5 autoinc"); scan_chk(5, "R5 autoinc");

    // wrap 31 -> 0: R5
    cs_lo(); send_msb(3'b101, 3); send_msb(30, 6);
    write_nib(4'h1); write_nib(4'h2); write_nib(4'h3); write_nib(4'h4);
    cs_hi();
    model_m[30] = 4'h1; model_m[31] = 4'h2; model_m[0] = 4'h3; model_m[1] = 4'h4;
    scan_chk(31, "R5 wrap"); scan_chk(0, "R5 wrap"); scan_chk(1, "R5 wrap");

    // top address bit ignored: R3
    cs_lo(); send_msb(3'b101, 3); send_msb(6'b100111, 6); write_nib(4'h9); cs_hi();
    model_m[7] = 4'h9;
    scan_chk(7, "R3 address msb ignored");

    // partial nibble discarded: R4
    cs_lo(); send_msb(3'b101, 3); send_msb(10, 6); write_nib(4'hF); wr_bit(1); wr_bit(1); cs_hi();
    model_m[10] = 4'hF;
    scan_chk(10, "R4 full nibble"); scan_chk(11, "R4 partial dropped");

    // frame aborted by select, then strobes with select high: R1
    cs_lo(); wr_bit(1); wr_bit(0); cs_hi();
    cs_lo(); send_msb(3'b101, 3); send_msb(12, 6); write_nib(4'h6); cs_hi();
    model_m[12] = 4'h6;
    scan_chk(12, "R1 restart after abort");
    send_msb(3'b101, 3); send_msb(13, 6); write_nib(4'h7); hold();
    scan_chk(13, "R1 strobes with select high");

    // read burst with wrap: R6 R7 R5
    cs_lo(); send_msb(3'b110, 3); send_msb(30, 6);
    chk(data_oe === 1'b0, "R7 oe before read", data_oe, 0);
    read_nib(model_m[30]);
    chk(data_oe === 1'b1, "R7 oe during read", data_oe, 1);
    read_nib(model_m[31]); read_nib(model_m[0]); read_nib(model_m[1]);
    cs_hi();
    chk(data_oe === 1'b0, "R1 oe released", data_oe, 0);

    // write strobes in read frame ignored: R10
    cs_lo(); send_msb(3'b110, 3); send_msb(3, 6);
    read_nib(model_m[3]); write_nib(4'hF); read_nib(model_m[4]);
    cs_hi();
    scan_chk(3, "R10 read frame no write"); scan_chk(4, "R10 read frame no write");

    // read-modify-write: R8
    cs_lo(); send_msb(3'b101, 3); send_msb(3, 6);
    read_nib(model_m[3]); write_nib(4'h1);
    read_nib(model_m[4]); write_nib(4'h2);
    chk(data_oe === 1'b1, "R7 oe in rmw", data_oe, 1);
    cs_hi();
    model_m[3] = 4'h1; model_m[4] = 4'h2;
    scan_chk(3, "R8 rmw write"); scan_chk(4, "R8 rmw write"); scan_chk(5, "R8 no extra advance");

    // commands: R9
    cs_lo(); send_msb(3'b100, 3);
    exp_cmd_q.push_back(9'h1A5); exp_cmd_q.push_back(9'h003);
    send_msb(9'h1A5, 9); send_msb(9'h003, 9);
    hold();
    chk(cmd_seen == 2, "R9 two commands", cmd_seen, 2);
    send_msb(5'b10110, 5); cs_hi(); hold();
    chk(cmd_seen == 2, "R9 partial dropped", cmd_seen, 2);
    scan_chk(0, "R9 cmd no ram write");

    // unknown frame code: R2
    cs_lo(); send_msb(3'b111, 3); send_msb(20, 6); write_nib(4'hF);
    rd_bit(); rd_bit();
    chk(data_oe === 1'b0, "R2 skip no drive", data_oe, 0);
    cs_hi();
    scan_chk(20, "R2 skip no write");
    chk(cmd_seen == 2, "R2 skip no cmd", cmd_seen, 2);

    chk(exp_rd_q.size() == 0 && exp_cmd_q.size() == 0, "R6 R9 scoreboard drained",
        exp_rd_q.size() + exp_cmd_q.size(), 0);
    finish_run();
  end
endmodule